// File: doc/BRIEF.md
# Interleaved PCM Bus Slot Scheduler

This block lets one framer share a high-speed serial PCM backplane with up to seven other framers. Each stream carries 32 eight-bit channels per 125 us frame; the shared bus runs at two, four or eight times the single-stream rate, so it carries that many streams. A 3-bit position value gives each device exclusive slots on the bus. An interleave-mode bit chooses the order. In channel-interleave order, the devices take turns one channel at a time. In frame-interleave order, each device sends its whole frame as one contiguous block.

All devices count bus bit periods from a common 8 kHz frame sync. One device is set as the sync master and generates the pulse; all others take it as an input. The block reads each outgoing byte from a show-ahead elastic-store read port one bit period before that byte goes on the bus. It shifts the byte out MSB first under a tri-state enable. On the receive side it collects the bits of its own slots into bytes, each tagged with a channel number.

Top module: `pcm_slot_sched`

## Requirements
- R1: With rate code r (0, 1, 2 for 2-, 4-, 8-way sharing), a bus frame is 256·N bit periods long, where N = 2^(r+1). A sync master pulses `fs_out` for exactly one cycle, in the last bit period of every frame.
- R2: A slave (`fs_master`=0) makes the bit period after a cycle with `fs_in` high bit 0 of a frame. A slave drives nothing before its first sync and never raises `fs_out`. A master ignores `fs_in`.
- R3: In channel-interleave order (`frame_ilv`=0), slot s (bit periods 8s..8s+7) belongs to the device when s mod N equals `bus_pos`. It carries channel s/N.
- R4: In frame-interleave order (`frame_ilv`=1), the device owns slots 32·`bus_pos` through 32·`bus_pos`+31. Slot s carries channel s mod 32.
- R5: A `bus_pos` of N or more, or the reserved rate code 3, is a configuration error. In that case `dout_en` and `es_rd` never assert. Rate code 3 keeps the 8-way frame length.
- R6: `es_rd` is high for one cycle, in the bit period just before the first bit of each owned slot. During that cycle `es_chan` gives the slot's channel, and `es_rdata` is taken at the end of the cycle.
- R7: During an owned slot `dout_en` is high for all 8 bit periods and `dout` gives the fetched byte MSB first. Outside owned slots, `dout_en` and `dout` are 0.
- R8: An owned slot whose read strobe was missed, because sync was acquired too late, is left undriven.
- R9: `din` is sampled at the end of each owned bit period, MSB first. One cycle after a slot's last bit, `rx_valid` pulses with the byte in `rx_data` and its channel in `rx_chan`.
- R10: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, one cycle per bus bit period |
| rst | input | 1 | Synchronous active-high reset |
| fs_master | input | 1 | 1: generate frame sync; 0: follow `fs_in` |
| fs_in | input | 1 | Shared frame sync input (slave) |
| fs_out | output | 1 | Generated frame sync (master) |
| rate_sel | input | 2 | Bus rate code: 0 two-way, 1 four-way, 2 eight-way, 3 reserved |
| bus_pos | input | 3 | Exclusive position of this device |
| frame_ilv | input | 1 | 0 channel interleave, 1 frame interleave |
| es_rd | output | 1 | Elastic-store read strobe |
| es_chan | output | 5 | Channel number being read |
| es_rdata | input | 8 | Elastic-store read data (show-ahead) |
| dout | output | 1 | Transmit bus data |
| dout_en | output | 1 | Tri-state enable for `dout` |
| din | input | 1 | Receive bus data |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_chan | output | 5 | Channel of received byte |

## Verification
The bench goes after the slot arithmetic at every rate in both orders, including the last position at 8-way sharing and the wrap from the last slot of a frame to slot 0. A wrong modulus or shift would make the device drive another device's slot, and that shows up as an owned-bit count different from 256 or as an enable in the wrong period. It also probes out-of-range positions and the reserved rate code, where a missing check causes bus contention. Slave acquisition and mid-frame realignment are probed, where an off-by-one in sync handling moves every strobe by one bit. So is the missed-strobe slot right after lock, which a careless design would fill with stale data.

// File: rtl/pcm_ibo_pkg.sv
package pcm_ibo_pkg;
  typedef enum logic {
    ILV_CHANNEL = 1'b0,
    ILV_FRAME   = 1'b1
  } ilv_mode_e;
endpackage

// File: rtl/pcm_frame_timer.sv
// Bus bit counter aligned to the shared 8 kHz frame sync.
module pcm_frame_timer #(
  parameter int CNT_W     = 11,
  parameter int FRAME_LOG = 8,
  parameter int LOG_W     = 2,
  parameter int BIT_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_master,
  input  logic             fs_in,
  input  logic [LOG_W-1:0] ways_log,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [BIT_W-1:0] phase_q,
  output logic             locked_nxt,
  output logic             fs_out
);
  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             sync_hit;

  always_comb begin
    span       = {{CNT_W{1'b0}}, 1'b1} << (FRAME_LOG + int'(ways_log));
    last       = CNT_W'(span - 1'b1);
    sync_hit   = !fs_master && fs_in;
    if (sync_hit)
      cnt_nxt = '0;
    else if (cnt_q == last)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + 1'b1;
    locked_nxt = fs_master || locked_q || fs_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      fs_out   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      locked_q <= locked_nxt;
      fs_out   <= fs_master && (cnt_nxt == last);
    end
  end

  assign phase_q = cnt_q[BIT_W-1:0];

  // R1: the generated pulse marks the last period; a new frame follows
  p_fs_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    fs_out |=> (cnt_q == '0));
  // R2: slave sync makes the next period bit 0
  p_slave_align_r2: assert property (@(posedge clk) disable iff (rst)
    (!fs_master && fs_in) |=> (cnt_q == '0));
  // R2: slaves never generate sync
  p_slave_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !fs_master |=> !fs_out);
endmodule

// File: rtl/pcm_slot_map.sv
// Decides whether a bus slot belongs to this device and which channel it carries.
module pcm_slot_map
  import pcm_ibo_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int CHW    = 5,
  parameter int LOG_W  = 2,
  parameter int POS_W  = 3
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [LOG_W-1:0]  ways_log,
  input  logic [POS_W-1:0]  pos,
  input  ilv_mode_e         mode,
  input  logic              cfg_ok,
  output logic              own,
  output logic [CHW-1:0]    chan
);
  logic [SLOT_W-1:0] way_mask;

  always_comb begin
    way_mask = SLOT_W'((1 << ways_log) - 1);
    if (mode == ILV_FRAME) begin
      own  = cfg_ok && ((slot >> CHW) == SLOT_W'(pos));
      chan = slot[CHW-1:0];
    end else begin
      own  = cfg_ok && ((slot & way_mask) == SLOT_W'(pos));
      chan = CHW'(slot >> ways_log);
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
// Loads a byte on the read strobe and shifts it out MSB first.
module pcm_tx_serializer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [BW-1:0] ld_data,
  input  logic          drive_nxt,
  output logic          dout,
  output logic          dout_en
);
  logic [BW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= drive_nxt;
      if (load) begin
        sh_q <= ld_data << 1;
        dout <= drive_nxt && ld_data[BW-1];
      end else begin
        sh_q <= sh_q << 1;
        dout <= drive_nxt && sh_q[BW-1];
      end
    end
  end

  // R7: data is only nonzero while the enable is up
  p_quiet_line_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> !dout);
endmodule

// File: rtl/pcm_rx_deserializer.sv
// Collects owned bus bits into bytes.
module pcm_rx_deserializer #(
  parameter int BW  = 8,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample,
  input  logic           last_bit,
  input  logic           din,
  input  logic [CHW-1:0] chan_in,
  output logic [BW-1:0]  rx_data,
  output logic           rx_valid,
  output logic [CHW-1:0] rx_chan
);
  logic [BW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_chan  <= '0;
    end else begin
      rx_valid <= sample && last_bit;
      if (sample) begin
        sh_q <= {sh_q[BW-2:0], din};
        if (last_bit) begin
          rx_data <= {sh_q[BW-2:0], din};
          rx_chan <= chan_in;
        end
      end
    end
  end

  // R9: a byte is only delivered right after an owned bit period
  p_rx_after_sample_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(sample));
  // R9: one strobe per slot
  p_rx_single_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/pcm_slot_sched.sv
// Interleaved PCM bus slot scheduler: top level.
module pcm_slot_sched
  import pcm_ibo_pkg::*;
#(
  parameter int CH_PER_STREAM = 32,
  parameter int BW            = 8,
  parameter int MAX_LOG       = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 fs_master,
  input  logic                                 fs_in,
  output logic                                 fs_out,
  input  logic [$clog2(MAX_LOG+1)-1:0]         rate_sel,
  input  logic [MAX_LOG-1:0]                   bus_pos,
  input  logic                                 frame_ilv,
  output logic                                 es_rd,
  output logic [$clog2(CH_PER_STREAM)-1:0]     es_chan,
  input  logic [BW-1:0]                        es_rdata,
  output logic                                 dout,
  output logic                                 dout_en,
  input  logic                                 din,
  output logic [BW-1:0]                        rx_data,
  output logic                                 rx_valid,
  output logic [$clog2(CH_PER_STREAM)-1:0]     rx_chan
);
  localparam int LOG_W     = $clog2(MAX_LOG + 1);
  localparam int POS_W     = MAX_LOG;
  localparam int CHW       = $clog2(CH_PER_STREAM);
  localparam int BIT_W     = $clog2(BW);
  localparam int SLOT_W    = CHW + MAX_LOG;
  localparam int CNT_W     = SLOT_W + BIT_W;
  localparam int FRAME_LOG = CHW + BIT_W;

  logic                rate_ok, cfg_ok;
  logic [LOG_W-1:0]    ways_log;
  logic [SLOT_W:0]     n_slots;
  logic [SLOT_W-1:0]   slot_mask, slot_a, slot_b;
  logic [CNT_W-1:0]    cnt_nxt;
  logic [BIT_W-1:0]    phase_q;
  logic                locked_nxt;
  logic                own_a, own_b, drive_nxt;
  logic [CHW-1:0]      chan_a, chan_b, chan_q;
  logic                rd_stb_q, seen_q, rx_own_q;
  ilv_mode_e           mode;

  always_comb begin
    rate_ok   = (int'(rate_sel) < MAX_LOG);
    ways_log  = rate_ok ? LOG_W'(rate_sel + 1'b1) : LOG_W'(MAX_LOG);
    cfg_ok    = rate_ok && (int'(bus_pos) < (1 << ways_log));
    mode      = ilv_mode_e'(frame_ilv);
    n_slots   = {{SLOT_W{1'b0}}, 1'b1} << (CHW + int'(ways_log));
    slot_mask = SLOT_W'(n_slots - 1'b1);
    slot_a    = cnt_nxt[CNT_W-1:BIT_W];
    slot_b    = (slot_a + 1'b1) & slot_mask;
    drive_nxt = own_a && locked_nxt && (seen_q || rd_stb_q);
  end

  pcm_frame_timer #(
    .CNT_W(CNT_W), .FRAME_LOG(FRAME_LOG), .LOG_W(LOG_W), .BIT_W(BIT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .fs_master(fs_master), .fs_in(fs_in),
    .ways_log(ways_log), .cnt_nxt(cnt_nxt), .phase_q(phase_q),
    .locked_nxt(locked_nxt), .fs_out(fs_out)
  );

  // slot in the coming bit period, and the slot after it (for the read strobe)
  pcm_slot_map #(
    .SLOT_W(SLOT_W), .CHW(CHW), .LOG_W(LOG_W), .POS_W(POS_W)
  ) u_map_cur (
    .slot(slot_a), .ways_log(ways_log), .pos(bus_pos), .mode(mode),
    .cfg_ok(cfg_ok), .own(own_a), .chan(chan_a)
  );

  pcm_slot_map #(
    .SLOT_W(SLOT_W), .CHW(CHW), .LOG_W(LOG_W), .POS_W(POS_W)
  ) u_map_ahead (
    .slot(slot_b), .ways_log(ways_log), .pos(bus_pos), .mode(mode),
    .cfg_ok(cfg_ok), .own(own_b), .chan(chan_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb_q <= 1'b0;
      es_chan  <= '0;
      seen_q   <= 1'b0;
      rx_own_q <= 1'b0;
      chan_q   <= '0;
    end else begin
      rd_stb_q <= (cnt_nxt[BIT_W-1:0] == BIT_W'(BW - 1)) && own_b && locked_nxt;
      es_chan  <= chan_b;
      if (rd_stb_q)
        seen_q <= 1'b1;
      rx_own_q <= own_a && locked_nxt;
      chan_q   <= chan_a;
    end
  end

  assign es_rd = rd_stb_q;

  pcm_tx_serializer #(.BW(BW)) u_tx (
    .clk(clk), .rst(rst), .load(rd_stb_q), .ld_data(es_rdata),
    .drive_nxt(drive_nxt), .dout(dout), .dout_en(dout_en)
  );

  pcm_rx_deserializer #(.BW(BW), .CHW(CHW)) u_rx (
    .clk(clk), .rst(rst), .sample(rx_own_q),
    .last_bit(phase_q == BIT_W'(BW - 1)), .din(din), .chan_in(chan_q),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_chan(rx_chan)
  );

  // R5: a bad configuration never reaches the bus
  p_cfg_err_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> (!dout_en && !es_rd));
  // R6: every strobe is followed by driving the fetched slot
  p_strobe_then_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (es_rd && !(fs_in && !fs_master)) |=> dout_en);
  // R6: the strobe lasts a single bit period
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    es_rd |=> !es_rd);
  // R7: inside a slot the enable never starts late
  p_drive_contig_r7: assert property (@(posedge clk) disable iff (rst)
    (dout_en && phase_q != '0) |-> $past(dout_en));
endmodule

// File: tb/test_pcm_slot_sched.sv
`timescale 1ns/1ps
module test_pcm_slot_sched;
  typedef struct packed {
    logic [1:0] rate;
    logic [2:0] pos;
    logic       fr;
    logic [8:0] exp_bits;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 1'b0, 9'd256},
    '{2'd0, 3'd1, 1'b1, 9'd256},
    '{2'd1, 3'd2, 1'b0, 9'd256},
    '{2'd1, 3'd3, 1'b1, 9'd256},
    '{2'd2, 3'd7, 1'b0, 9'd256},
    '{2'd2, 3'd5, 1'b1, 9'd256},
    '{2'd2, 3'd0, 1'b1, 9'd256},
    '{2'd0, 3'd2, 1'b0, 9'd0},
    '{2'd1, 3'd4, 1'b1, 9'd0},
    '{2'd3, 3'd0, 1'b0, 9'd0}
  };

  logic clk = 1'b0;
  logic rst, fs_master, fs_in, frame_ilv, din;
  logic [1:0] rate_sel;
  logic [2:0] bus_pos;
  logic [7:0] es_rdata;
  logic fs_out, es_rd, dout, dout_en, rx_valid;
  logic [4:0] es_chan, rx_chan;
  logic [7:0] rx_data;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_slot_sched i_pcm_slot_sched (
    .clk(clk), .rst(rst), .fs_master(fs_master), .fs_in(fs_in), .fs_out(fs_out),
    .rate_sel(rate_sel), .bus_pos(bus_pos), .frame_ilv(frame_ilv),
    .es_rd(es_rd), .es_chan(es_chan), .es_rdata(es_rdata),
    .dout(dout), .dout_en(dout_en), .din(din),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_chan(rx_chan)
  );

  function automatic int wlog(int r); return (r > 2) ? 3 : r + 1; endfunction
  function automatic bit m_own(int s, int r, int p, bit fr);
    int n;
    if (r > 2) return 0;
    n = 1 << (r + 1);
    if (p >= n) return 0;
    return fr ? ((s / 32) == p) : ((s % n) == p);
  endfunction
  function automatic int m_chan(int s, int r, bit fr);
    return fr ? (s % 32) : (s >> wlog(r));
  endfunction
  function automatic logic [7:0] f_es(int ch); return 8'(ch * 29 + 90); endfunction
  function automatic logic g_bit(int k); return 1'(((k * 5) >> 2) ^ (k >> 5)); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // show-ahead elastic store model: data follows the requested channel
  initial forever begin
    @(negedge clk);
    es_rdata = f_es(int'(es_chan));
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_fs();
    int w = 0;
    while (!fs_out && w < 5000) begin @(negedge clk); w++; end
  endtask

  task automatic run_vec(input vec_t v);
    int r = int'(v.rate), p = int'(v.pos);
    int fl = 256 << wlog(r);
    int ns = 32 << wlog(r);
    int en_bad = 0, rd_bad = 0, d_bad = 0, rx_bad = 0, fs_bad = 0, owned = 0;
    logic [7:0] rx_exp = '0;
    string req;
    req = (v.exp_bits == 0) ? "R5" : (v.fr ? "R4" : "R3");
    fs_master = 1'b1; fs_in = 1'b0; rate_sel = v.rate; bus_pos = v.pos; frame_ilv = v.fr;
    do_reset();
    wait_fs();
    for (int k = 0; k < fl; k++) begin
      int s = k >> 3, b = k & 7;
      bit own, exp_rd, exp_v;
      logic exp_d;
      @(negedge clk);
      own = m_own(s, r, p, v.fr);
      if (dout_en !== own) en_bad++;
      if (dout_en === 1'b1) owned++;
      exp_rd = (b == 7) && m_own((s + 1) % ns, r, p, v.fr);
      if (es_rd !== exp_rd) rd_bad++;
      else if (exp_rd && es_chan !== 5'(m_chan((s + 1) % ns, r, v.fr))) rd_bad++;
      exp_d = own ? f_es(m_chan(s, r, v.fr))[7 - b] : 1'b0;
      if (dout !== exp_d) d_bad++;
      if (fs_out !== (k == fl - 1)) fs_bad++;
      if (k >= 1) begin
        exp_v = (b == 0) && m_own(s - 1, r, p, v.fr);
        if (rx_valid !== exp_v) rx_bad++;
        else if (exp_v && (rx_data !== rx_exp || rx_chan !== 5'(m_chan(s - 1, r, v.fr)))) rx_bad++;
      end
      if (own) rx_exp = {rx_exp[6:0], g_bit(k)};
      din = g_bit(k);
    end
    check(en_bad == 0, {req, " enable per bit period"}, en_bad, 0);
    check(owned == int'(v.exp_bits), {req, " owned bits per frame"}, owned, int'(v.exp_bits));
    check(rd_bad == 0, "R6 strobe timing and channel", rd_bad, 0);
    check(d_bad == 0, "R7 serial data MSB first", d_bad, 0);
    check(rx_bad == 0, "R9 receive bytes", rx_bad, 0);
    check(fs_bad == 0, "R1 frame sync period", fs_bad, 0);
  endtask

  initial begin
    rst = 1'b1; fs_master = 1'b1; fs_in = 1'b0; rate_sel = 2'd1; bus_pos = 3'd0;
    frame_ilv = 1'b0; din = 1'b1; es_rdata = '0;
    repeat (3) @(negedge clk);
    // R10: outputs in reset
    check({fs_out, es_rd, dout, dout_en, rx_valid} == 5'b0 && es_chan == 0 &&
          rx_chan == 0 && rx_data == 0, "R10 reset outputs",
          int'({fs_out, es_rd, dout, dout_en, rx_valid}), 0);

    // table-driven sweep over rates, positions and orders
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2 + R8: slave acquisition, channel order, 2-way, position 0
    begin
      int act = 0;
      fs_master = 1'b0; fs_in = 1'b0; rate_sel = 2'd0; bus_pos = 3'd0; frame_ilv = 1'b0;
      do_reset();
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        act += int'(dout_en) + int'(es_rd) + int'(fs_out);
      end
      check(act == 0, "R2 slave silent before sync", act, 0);
      fs_in = 1'b1;
      @(negedge clk);
      fs_in = 1'b0;
      act = 0;
      for (int k = 0; k < 8; k++) begin
        act += int'(dout_en);
        @(negedge clk);
      end
      check(act == 0, "R8 unfetched first slot left undriven", act, 0);
      repeat (6) @(negedge clk);
      check(es_rd == 1'b0, "R2 no strobe at bit 14", int'(es_rd), 0);
      @(negedge clk);
      check(es_rd == 1'b1 && es_chan == 5'd1, "R2 strobe at bit 15 after sync",
            int'(es_rd), 1);
      @(negedge clk);
      check(dout_en == 1'b1 && dout == f_es(1)[7], "R8 fetched slot driven at bit 16",
            int'(dout_en), 1);
      repeat (284) @(negedge clk);
      fs_in = 1'b1;
      @(negedge clk);
      fs_in = 1'b0;
      repeat (14) @(negedge clk);
      check(es_rd == 1'b0, "R2 realigned: no strobe at bit 14", int'(es_rd), 0);
      @(negedge clk);
      check(es_rd == 1'b1, "R2 realigned: strobe at bit 15", int'(es_rd), 1);
      check(fs_out == 1'b0, "R2 slave never drives sync", int'(fs_out), 0);
    end

    // R2: master ignores fs_in
    begin
      int bad = 0;
      fs_master = 1'b1; rate_sel = 2'd1; bus_pos = 3'd1; frame_ilv = 1'b0;
      do_reset();
      wait_fs();
      for (int k = 0; k < 1024; k++) begin
        @(negedge clk);
        fs_in = (k == 100);
        if (fs_out !== (k == 1023)) bad++;
      end
      fs_in = 1'b0;
      check(bad == 0, "R2 master ignores fs_in", bad, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule